// File: doc/BRIEF.md
# Head Step and Restore Sequencer

This block moves the read/write heads of a disk drive by producing a train of active-low step pulses together with a direction level. A controller starts it with a one-cycle strobe. For a seek it supplies the present and the wanted cylinder. For a restore it asks the block to drive the heads outward until the drive reports track zero. The same sequencer serves hard disks and floppies. The drive-type input picks the restore pulse limit and the way the restore is paced. A seek can be explicit or implied. In both cases the caller places the step-rate code for that kind of seek on the rate input.

Each step is preceded by a check cycle. In that cycle the sequencer looks at the track-zero input and at its own counters before it commits to the next pulse. When the motion is complete, the sequencer raises a single-cycle done pulse. A restore that runs out of pulses without reaching track zero also raises a sticky error flag, which the next start clears. A seek never waits for seek complete from the drive, so the caller can overlap seeks on several drives.

Top module: `step_seq`

## Requirements
- R1: A seek (restore_i=0) issues exactly |tgt_cyl_i - cur_cyl_i| step pulses and then finishes. Equal cylinders give no pulse and a done pulse two cycles after the start is sampled.
- R2: dir_o is 1 (outward) for a restore or when the target is below the current cylinder, and 0 (inward) otherwise. It takes its value at the clock edge that accepts the start, at least two cycles before the first falling edge of step_n_o, and it holds that value until done.
- R3: Every step pulse keeps step_n_o low for exactly PULSE_W clock cycles.
- R4: During a seek, the falling edges of step_n_o are exactly (rate_i+1)*TICK_DIV clock cycles apart.
- R5: The track-zero input is sampled in the cycle before each step. In outward motion, no pulse is issued while it is high, and an outward seek that meets track zero ends early with done and no error.
- R6: A restore finishes with done and no error as soon as track zero is seen before a step. If track zero is already high at the start, no pulse is issued.
- R7: If a restore has issued HD_LIMIT pulses (hard disk, floppy_i=0) or FD_LIMIT pulses (floppy_i=1) and still sees no track zero at the next check, trk0_err_o goes to 1 in the same cycle as done_o.
- R8: In a hard-disk restore, each next step waits until seek_cmplt_i is high, and rate_i has no effect. With seek_cmplt_i held high, the falling edges are PULSE_W+2 cycles apart.
- R9: In a floppy restore, the falling edges are max((rate_i+1)*TICK_DIV, FD_MIN_CLKS) cycles apart, where FD_MIN_CLKS stands for the 8 ms floor.
- R10: A seek does not look at seek_cmplt_i. It completes with seek_cmplt_i held low throughout.
- R11: done_o is a single-cycle pulse one clock after the final check. After reset step_n_o=1, done_o=0 and trk0_err_o=0. trk0_err_o keeps its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start strobe, accepted only while idle |
| restore_i | input | 1 | 1 = restore to track zero, 0 = seek |
| floppy_i | input | 1 | 1 = floppy drive, 0 = hard disk |
| cur_cyl_i | input | CYL_W | Present cylinder (seek) |
| tgt_cyl_i | input | CYL_W | Wanted cylinder (seek) |
| rate_i | input | RATE_W | Step-rate code |
| trk0_i | input | 1 | Drive reports heads on the outermost cylinder |
| seek_cmplt_i | input | 1 | Drive reports the heads have settled |
| step_n_o | output | 1 | Step pulse, active low |
| dir_o | output | 1 | 1 = outward, 0 = inward |
| done_o | output | 1 | One-cycle completion pulse |
| trk0_err_o | output | 1 | Restore ran out of pulses without track zero |

## Verification
On every cycle the assertions check the following. The pulse low width is exact. The direction stays steady for the whole operation. No outward pulse follows a cycle in which track zero was high. The pulse counter never passes its limit. Done lasts one cycle with the step line high, and the error flag rises only together with done. Other behaviours need the bench's scenarios, which compare results against expectations the bench computes itself. These are the pulse count per operation, the spacing between falling edges for each pacing mode, the early stop at track zero, the two restore limits, and the hold-off of a hard-disk restore while seek complete is low.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CHECK,
    ST_PULSE,
    ST_GAP,
    ST_WAITSC,
    ST_DONE
  } seq_state_e;

  // Clocks between falling edges for a rate code.
  function automatic int unsigned rate_period(int unsigned rate, int unsigned tick_div);
    return (rate + 1) * tick_div;
  endfunction

  // Applies a lower bound to a period.
  function automatic int unsigned floor_period(int unsigned p, int unsigned floor_clks);
    return (p < floor_clks) ? floor_clks : p;
  endfunction

  // Number of cylinders between two positions.
  function automatic int unsigned cyl_span(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/step_tally.sv
module step_tally #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] span_i,
  input  logic             issue_i,
  output logic [CNT_W-1:0] issued_o,
  output logic             left_zero_o
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      issued_q <= '0;
    end else if (load_i) begin
      left_q   <= span_i;
      issued_q <= '0;
    end else if (issue_i) begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      issued_q <= issued_q + 1'b1;
    end
  end

  assign issued_o    = issued_q;
  assign left_zero_o = (left_q == '0);
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int unsigned CYL_W       = 10,
  parameter int unsigned RATE_W      = 4,
  parameter int unsigned TICK_DIV    = 8,
  parameter int unsigned PULSE_W     = 3,
  parameter int unsigned FD_MIN_CLKS = 40,
  parameter int unsigned HD_LIMIT    = 1023,
  parameter int unsigned FD_LIMIT    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              restore_i,
  input  logic              floppy_i,
  input  logic [CYL_W-1:0]  cur_cyl_i,
  input  logic [CYL_W-1:0]  tgt_cyl_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              trk0_i,
  input  logic              seek_cmplt_i,
  output logic              step_n_o,
  output logic              dir_o,
  output logic              done_o,
  output logic              trk0_err_o
);
  localparam int unsigned RATE_MAXP = (2 ** RATE_W) * TICK_DIV;
  localparam int unsigned MAX_P     = (RATE_MAXP > FD_MIN_CLKS) ? RATE_MAXP : FD_MIN_CLKS;
  localparam int unsigned TMR_W     = $clog2(MAX_P + 1);
  localparam int unsigned LIM_MAX   = (HD_LIMIT > FD_LIMIT) ? HD_LIMIT : FD_LIMIT;
  localparam int unsigned SPAN_MAX  = 2 ** CYL_W;
  localparam int unsigned CNT_W     = $clog2(((LIM_MAX > SPAN_MAX) ? LIM_MAX : SPAN_MAX) + 1);

  seq_state_e        state_q, state_d;
  logic              restore_q, floppy_q, dir_q, err_q;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  limit_q;

  // Named internal events.
  logic              ev_accept, ev_issue, ev_finish, ev_limit;
  logic              hd_restore, tmr_zero, tmr_load, left_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  issued, span;
  int unsigned       period_clks, gap_clks;

  assign hd_restore = restore_q && !floppy_q;
  assign ev_accept  = (state_q == ST_IDLE) && start_i;
  assign span       = CNT_W'(cyl_span(32'(cur_cyl_i), 32'(tgt_cyl_i)));

  assign period_clks = (restore_q && floppy_q)
                     ? floor_period(rate_period(32'(rate_q), TICK_DIV), FD_MIN_CLKS)
                     : rate_period(32'(rate_q), TICK_DIV);
  assign gap_clks    = period_clks - PULSE_W - 1;

  // Decision taken in the check cycle before every step.
  always_comb begin
    ev_issue  = 1'b0;
    ev_finish = 1'b0;
    ev_limit  = 1'b0;
    if (state_q == ST_CHECK) begin
      if (restore_q) begin
        if (trk0_i)                  ev_finish = 1'b1;
        else if (issued == limit_q) begin
          ev_finish = 1'b1;
          ev_limit  = 1'b1;
        end else                     ev_issue  = 1'b1;
      end else begin
        if (left_zero || (dir_q && trk0_i)) ev_finish = 1'b1;
        else                                ev_issue  = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_CHECK;
      ST_CHECK:  state_d = ev_finish ? ST_DONE : ST_PULSE;
      ST_PULSE:  if (tmr_zero) state_d = hd_restore ? ST_WAITSC : ST_GAP;
      ST_GAP:    if (tmr_zero) state_d = ST_CHECK;
      ST_WAITSC: if (seek_cmplt_i) state_d = ST_CHECK;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = ev_issue || ((state_q == ST_PULSE) && tmr_zero && !hd_restore);
  assign tmr_val  = (state_q == ST_CHECK) ? TMR_W'(PULSE_W - 1) : TMR_W'(gap_clks - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      restore_q <= 1'b0;
      floppy_q  <= 1'b0;
      dir_q     <= 1'b0;
      err_q     <= 1'b0;
      rate_q    <= '0;
      limit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        restore_q <= restore_i;
        floppy_q  <= floppy_i;
        dir_q     <= restore_i || (tgt_cyl_i < cur_cyl_i);
        err_q     <= 1'b0;
        rate_q    <= rate_i;
        limit_q   <= CNT_W'(floppy_i ? FD_LIMIT : HD_LIMIT);
      end else if (ev_limit) begin
        err_q <= 1'b1;
      end
    end
  end

  step_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  step_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .load_i(ev_accept), .span_i(span),
    .issue_i(ev_issue), .issued_o(issued), .left_zero_o(left_zero)
  );

  assign step_n_o   = (state_q != ST_PULSE);
  assign dir_o      = dir_q;
  assign done_o     = (state_q == ST_DONE);
  assign trk0_err_o = err_q;

  // Observation counter for the low-width property.
  logic [TMR_W-1:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt_q <= '0;
    else if (step_n_o) low_cnt_q <= '0;
    else               low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_n_o) |-> (low_cnt_q == TMR_W'(PULSE_W)));

  assert_dir_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(dir_o));

  assert_trk0_before_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(step_n_o) && dir_o) |-> !$past(trk0_i));

  assert_limit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |-> (issued <= limit_q));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trk0_err_o) |-> done_o);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_step_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> step_n_o);

endmodule

// File: tb/step_seq_tb.sv
module step_seq_tb;
  localparam int PW    = 3;
  localparam int TDIV  = 8;
  localparam int FDMIN = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, restore = 1'b0, floppy = 1'b0;
  logic [9:0] cur = '0, tgt = '0;
  logic [3:0] rate = '0;
  logic       trk0_pre = 1'b0, trk0_hit = 1'b0, sc = 1'b0;
  logic       trk0_w;
  logic       step_n, dir, done, err;

  assign trk0_w = trk0_pre | trk0_hit;

  always #10 clk = ~clk;

  step_seq #(.TICK_DIV(TDIV), .PULSE_W(PW), .FD_MIN_CLKS(FDMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .restore_i(restore), .floppy_i(floppy),
    .cur_cyl_i(cur), .tgt_cyl_i(tgt), .rate_i(rate), .trk0_i(trk0_w),
    .seek_cmplt_i(sc), .step_n_o(step_n), .dir_o(dir), .done_o(done), .trk0_err_o(err)
  );

  typedef struct { int pulses; bit err; string tag; } exp_t;
  exp_t sb[$];

  int    checks = 0, errors = 0;
  int    cyc = 0, pcount = 0, last_fall = 0, low_run = 0, dones = 0;
  int    exp_dir = 0, exp_period = 0, trk0_after = -1;
  string exp_tag = "R4";
  bit    prev_step = 1'b1, prev_done = 1'b0;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: samples at the falling edge.
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst_n) begin
      if (start) begin
        pcount   = 0;
        trk0_hit = 1'b0;
      end
      if (prev_step && !step_n) begin
        pcount++;
        check(dir == exp_dir[0], "R2", int'(dir), exp_dir);
        if (pcount > 1 && exp_period != 0)
          check(cyc - last_fall == exp_period, exp_tag, cyc - last_fall, exp_period);
        last_fall = cyc;
        if (trk0_after > 0 && pcount == trk0_after) trk0_hit = 1'b1;
      end
      if (!prev_step && step_n) check(low_run == PW, "R3", low_run, PW);
      low_run = step_n ? 0 : low_run + 1;
      if (prev_done && done) check(1'b0, "R11", 2, 1);
      if (done) begin
        if (sb.size() == 0) check(1'b0, "R11", 0, 1);
        else begin
          e = sb.pop_front();
          check(pcount == e.pulses, e.tag, pcount, e.pulses);
          check(err == e.err, "R7", int'(err), int'(e.err));
        end
        dones++;
      end
    end
    prev_step = step_n;
    prev_done = done;
  end

  task automatic run(bit rs, bit fd, int c, int t, int r, int np, bit ex_err,
                     int ex_dir, int per, string ptag, string ctag, int t0, bit scv);
    exp_t e;
    int   d;
    @(posedge clk); #5;
    restore = rs; floppy = fd; cur = 10'(c); tgt = 10'(t); rate = 4'(r);
    trk0_pre = (t0 == 0); trk0_after = t0; sc = scv;
    exp_dir = ex_dir; exp_period = per; exp_tag = ptag;
    e.pulses = np; e.err = ex_err; e.tag = ctag;
    sb.push_back(e);
    d = dones;
    start = 1'b1;
    @(posedge clk); #5;
    start = 1'b0;
    wait (dones != d);
    @(posedge clk); #5;
    trk0_pre = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    int   d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(step_n == 1'b1, "R11", int'(step_n), 1);
    check(done == 1'b0, "R11", int'(done), 0);
    check(err == 1'b0, "R11", int'(err), 0);
    @(posedge clk); #5 rst_n = 1'b1;

    // R1 R4 R10: inward seek, seek complete held low
    run(0, 0, 5, 12, 2, 7, 0, 0, 3 * TDIV, "R4", "R1", -1, 0);
    // R1 R2 R4: outward seek, rate 0
    run(0, 0, 20, 14, 0, 6, 0, 1, TDIV, "R4", "R1", -1, 1);
    // R1: zero distance
    run(0, 0, 9, 9, 5, 0, 0, 0, 0, "R4", "R1", -1, 0);
    // R5: outward seek stops early at track zero
    run(0, 0, 30, 0, 1, 4, 0, 1, 2 * TDIV, "R4", "R5", 4, 0);
    // R6: restore with track zero already high
    run(1, 1, 0, 0, 0, 0, 0, 1, 0, "R9", "R6", 0, 0);
    // R6 R9: floppy restore hits the 40-clock floor
    run(1, 1, 0, 0, 0, 5, 0, 1, FDMIN, "R9", "R6", 5, 0);
    // R9: floppy restore slower than floor
    run(1, 1, 0, 0, 7, 2, 0, 1, 8 * TDIV, "R9", "R6", 2, 0);
    // R7: floppy restore limit
    run(1, 1, 0, 0, 0, 256, 1, 1, FDMIN, "R9", "R7", -1, 0);
    // R7 R8: hard-disk restore limit, rate ignored
    run(1, 0, 0, 0, 15, 1023, 1, 1, PW + 2, "R8", "R7", -1, 1);
    repeat (5) @(negedge clk);
    check(err == 1'b1, "R11", int'(err), 1);

    // R8: hard-disk restore held off while seek complete is low
    @(posedge clk); #5;
    restore = 1'b1; floppy = 1'b0; rate = 4'd0; sc = 1'b0;
    trk0_pre = 1'b0; trk0_after = 2; exp_dir = 1; exp_period = 0; exp_tag = "R8";
    e.pulses = 2; e.err = 1'b0; e.tag = "R8";
    sb.push_back(e);
    d = dones;
    start = 1'b1;
    @(posedge clk); #5 start = 1'b0;
    @(negedge clk);
    check(err == 1'b0, "R11", int'(err), 0);
    while (pcount < 1) @(negedge clk);
    repeat (50) @(negedge clk);
    check(pcount == 1, "R8", pcount, 1);
    @(posedge clk); #5 sc = 1'b1;
    wait (dones != d);
    repeat (2) @(posedge clk);

    check(sb.size() == 0, "R1", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule